// File: doc/BRIEF.md
# Transmit DMA Write Port with Word-Count Checking

This block sits between the system bus and a set of transmit lanes. Each time the transmit timing logic reaches a service point, the block raises a one-cycle service request toward the DMA engine or CPU. It then expects exactly one data word for every lane that is both enabled and set to transmit.

Each accepted word is handed to the next such lane, starting from the lowest lane index. A write beyond that quota is dropped, and a sticky error flag records that the bus master and the port have fallen out of step. When this happens, both the transmitter and the DMA must be re-initialized. If the master sends too few words, this block raises no error. The lanes that received no word report underrun on their own.

Lane enable and direction settings are captured only while the transmitter is held in reset. They stay frozen while it runs.

Top module: `tx_dma_port_chk`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `svc_req`, `lane_load`, `lane_word` and `dma_err` are all zero.
- R2: An `event_tick` sampled while `tx_hold` is low produces `svc_req` high for exactly one cycle, on the next cycle. A tick while `tx_hold` is high produces no request.
- R3: The k-th word (counting from 0) accepted in an event goes to the k-th lowest-index active lane. An active lane has its `lane_enable` bit at 1 and its `lane_dir_tx` bit at 1. On the cycle after the write, `lane_load` is one-hot at that lane's bit and `lane_word` carries the written data.
- R4: A lane whose enable bit or direction bit is 0 is never loaded.
- R5: A write arriving after every active lane has been loaded in the current event is dropped, with `lane_load` staying zero. `dma_err` goes high on the next cycle.
- R6: If an event receives fewer words than there are active lanes, `dma_err` is not raised. The next event starts again at the lowest active lane.
- R7: `dma_err` stays high until a cycle with `dma_err_clr` high, and is low on the following cycle. If an excess write arrives in the same cycle as the clear, the flag stays high.
- R8: The active-lane set is captured from `lane_enable` and `lane_dir_tx` only on cycles with `tx_hold` high. Changes to those inputs while `tx_hold` is low do not affect routing.
- R9: While `tx_hold` is high, writes are dropped without setting `dma_err`, no lane is loaded, and any open event is closed.
- R10: A write with no open event is treated as excess. This covers a write after reset or after hold release but before the first tick. Such a write is dropped and sets `dma_err`.
- R11: A write presented in the same cycle as an accepted `event_tick` counts as the first word of the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_hold | input | 1 | Transmitter held in reset; configuration is captured while high |
| lane_enable | input | NUM_LANES | Per-lane enable |
| lane_dir_tx | input | NUM_LANES | Per-lane direction, 1 = transmit |
| event_tick | input | 1 | Service point from the transmit timing logic |
| svc_req | output | 1 | One-cycle data request to the DMA/CPU |
| wr_valid | input | 1 | Bus write strobe for the data port |
| wr_data | input | DATA_W | Bus write data |
| lane_load | output | NUM_LANES | One-hot load strobe for the selected lane |
| lane_word | output | DATA_W | Word delivered with `lane_load` |
| dma_err | output | 1 | Sticky excess-write error flag |
| dma_err_clr | input | 1 | Write-one-to-clear for `dma_err` |

## Verification
The assertions check several properties on every cycle:
- `lane_load` is at most one-hot and never names an inactive lane.
- The word delivered matches the data written one cycle earlier.
- The request follows each tick that is not held, and hold keeps both outputs quiet.
- The error flag stays set until cleared, and a write with no open event raises it.

Other behaviour only the bench's scenarios can show, because it depends on a whole event: the ascending order in which lanes fill, the exact point at which the quota is exhausted, and the restart of the count after a short event. Two further points also need a scenario: configuration stays frozen while running, and a write in a tick cycle counts toward the new event.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    // Largest lane count the counters are sized for.
    localparam int unsigned MAX_LANES = 16;
    localparam int unsigned SLOT_W    = 5;

    typedef logic [MAX_LANES-1:0] lane_vec_t;
    typedef logic [SLOT_W-1:0]    slot_t;

    // Event phase of the write port.
    typedef enum logic [1:0] {
        EV_HELD = 2'd0,
        EV_IDLE = 2'd1,
        EV_OPEN = 2'd2
    } evt_state_t;

    // Per-write decision taken in the cycle of the bus write.
    typedef struct packed {
        logic  accept;
        logic  excess;
        slot_t slot;
    } wr_decision_t;

    // Number of set bits in a lane vector.
    function automatic slot_t count_lanes(input lane_vec_t v);
        slot_t c;
        c = '0;
        for (int i = 0; i < MAX_LANES; i++) begin
            c = c + slot_t'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/tdp_cfg_latch.sv
module tdp_cfg_latch
    import tdp_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold,
    input  logic [NUM_LANES-1:0] en_in,
    input  logic [NUM_LANES-1:0] tx_in,
    output logic [NUM_LANES-1:0] active
);

    // Configuration is only sampled while the transmitter is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (hold) begin
            active <= en_in & tx_in;
        end
    end

endmodule

// File: rtl/tdp_evt_seq.sv
module tdp_evt_seq
    import tdp_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold,
    input  logic                 tick,
    input  logic                 wr_valid,
    input  logic [NUM_LANES-1:0] active,
    output logic                 svc_req,
    output wr_decision_t         dec,
    output evt_state_t           state
);

    localparam slot_t CNT_SAT = slot_t'(NUM_LANES + 1);

    slot_t cnt;
    slot_t avail;
    slot_t idx;
    logic  open_now;

    always_comb begin
        avail      = count_lanes(lane_vec_t'(active));
        open_now   = tick || (state == EV_OPEN);
        idx        = tick ? '0 : cnt;
        dec.slot   = idx;
        dec.accept = wr_valid && !hold && open_now && (idx < avail);
        dec.excess = wr_valid && !hold && !dec.accept;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            state   <= EV_HELD;
            cnt     <= '0;
            svc_req <= 1'b0;
        end else begin
            svc_req <= tick;
            if (tick) begin
                state <= EV_OPEN;
                cnt   <= wr_valid ? slot_t'(1) : '0;
            end else begin
                if (state == EV_HELD) begin
                    state <= EV_IDLE;
                end
                if (wr_valid && (cnt != CNT_SAT)) begin
                    cnt <= cnt + slot_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tdp_router.sv
module tdp_router
    import tdp_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LANES-1:0] active,
    input  wr_decision_t         dec,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_LANES-1:0] lane_load,
    output logic [DATA_W-1:0]    lane_word
);

    logic [NUM_LANES-1:0] sel;
    slot_t                seen;

    // Find the dec.slot-th active lane, lowest index first.
    always_comb begin
        sel  = '0;
        seen = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (active[i]) begin
                if (seen == dec.slot) begin
                    sel[i] = 1'b1;
                end
                seen = seen + slot_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_load <= '0;
            lane_word <= '0;
        end else begin
            lane_load <= dec.accept ? sel : '0;
            if (dec.accept) begin
                lane_word <= wr_data;
            end
        end
    end

endmodule

// File: rtl/tdp_err_flag.sv
module tdp_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // A new excess write outranks a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_dma_port_chk.sv
module tx_dma_port_chk
    import tdp_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tx_hold,
    input  logic [NUM_LANES-1:0] lane_enable,
    input  logic [NUM_LANES-1:0] lane_dir_tx,
    input  logic                 event_tick,
    output logic                 svc_req,
    input  logic                 wr_valid,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_LANES-1:0] lane_load,
    output logic [DATA_W-1:0]    lane_word,
    output logic                 dma_err,
    input  logic                 dma_err_clr
);

    logic [NUM_LANES-1:0] cfg_active;
    wr_decision_t         wr_dec;
    evt_state_t           ev_state;

    tdp_cfg_latch #(.NUM_LANES(NUM_LANES)) cfg_i (
        .clk    (clk),
        .rst    (rst),
        .hold   (tx_hold),
        .en_in  (lane_enable),
        .tx_in  (lane_dir_tx),
        .active (cfg_active)
    );

    tdp_evt_seq #(.NUM_LANES(NUM_LANES)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .hold     (tx_hold),
        .tick     (event_tick),
        .wr_valid (wr_valid),
        .active   (cfg_active),
        .svc_req  (svc_req),
        .dec      (wr_dec),
        .state    (ev_state)
    );

    tdp_router #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) rtr_i (
        .clk       (clk),
        .rst       (rst),
        .active    (cfg_active),
        .dec       (wr_dec),
        .wr_data   (wr_data),
        .lane_load (lane_load),
        .lane_word (lane_word)
    );

    tdp_err_flag err_i (
        .clk  (clk),
        .rst  (rst),
        .set  (wr_dec.excess),
        .clr  (dma_err_clr),
        .flag (dma_err)
    );

endmodule

// File: rtl/tx_dma_port_chk_sva.sv
module tx_dma_port_chk_sva
    import tdp_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tx_hold,
    input logic                 event_tick,
    input logic                 svc_req,
    input logic                 wr_valid,
    input logic [DATA_W-1:0]    wr_data,
    input logic [NUM_LANES-1:0] lane_load,
    input logic [DATA_W-1:0]    lane_word,
    input logic                 dma_err,
    input logic                 dma_err_clr,
    input logic [NUM_LANES-1:0] cfg_active,
    input evt_state_t           ev_state
);

    AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_load)); // R3

    AST_WORD_MATCH: assert property (@(posedge clk) disable iff (rst)
        (|lane_load) |-> (lane_word == $past(wr_data))); // R3

    AST_LANE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (lane_load & ~cfg_active) == '0); // R4

    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (event_tick && !tx_hold) |=> svc_req); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (dma_err && !dma_err_clr) |=> dma_err); // R7

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (dma_err_clr && !wr_valid) |=> !dma_err); // R7

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        tx_hold |=> (!svc_req && (lane_load == '0))); // R9

    AST_HOLD_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (tx_hold && !dma_err) |=> !dma_err); // R9

    AST_ORPHAN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !tx_hold && !event_tick && (ev_state != EV_OPEN))
        |=> (dma_err && (lane_load == '0))); // R10

endmodule

bind tx_dma_port_chk tx_dma_port_chk_sva #(
    .NUM_LANES(NUM_LANES),
    .DATA_W   (DATA_W)
) sva_i (
    .clk         (clk),
    .rst         (rst),
    .tx_hold     (tx_hold),
    .event_tick  (event_tick),
    .svc_req     (svc_req),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .lane_load   (lane_load),
    .lane_word   (lane_word),
    .dma_err     (dma_err),
    .dma_err_clr (dma_err_clr),
    .cfg_active  (cfg_active),
    .ev_state    (ev_state)
);

// File: tb/tx_dma_port_chk_tb_top.sv
module tx_dma_port_chk_tb_top;

    localparam int unsigned NL = 4;
    localparam int unsigned DW = 32;

    logic          clk;
    logic          rst;
    logic          tx_hold;
    logic [NL-1:0] lane_enable;
    logic [NL-1:0] lane_dir_tx;
    logic          event_tick;
    logic          svc_req;
    logic          wr_valid;
    logic [DW-1:0] wr_data;
    logic [NL-1:0] lane_load;
    logic [DW-1:0] lane_word;
    logic          dma_err;
    logic          dma_err_clr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tx_dma_port_chk #(.NUM_LANES(NL), .DATA_W(DW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .tx_hold     (tx_hold),
        .lane_enable (lane_enable),
        .lane_dir_tx (lane_dir_tx),
        .event_tick  (event_tick),
        .svc_req     (svc_req),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .lane_load   (lane_load),
        .lane_word   (lane_word),
        .dma_err     (dma_err),
        .dma_err_clr (dma_err_clr)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected one-hot for the k-th active lane, ascending index.
    function automatic logic [NL-1:0] exp_lane(input logic [NL-1:0] act, input int k);
        logic [NL-1:0] r;
        int n;
        r = '0;
        n = 0;
        for (int i = 0; i < NL; i++) begin
            if (act[i] == 1'b1) begin
                if (n == k) r[i] = 1'b1;
                n++;
            end
        end
        return r;
    endfunction

    // Drive one cycle of inputs at a falling edge; return at the next one.
    task automatic step(input logic tk, input logic wv, input logic [DW-1:0] d, input logic clr);
        event_tick  = tk;
        wr_valid    = wv;
        wr_data     = d;
        dma_err_clr = clr;
        @(negedge clk);
        event_tick  = 1'b0;
        wr_valid    = 1'b0;
        dma_err_clr = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; tx_hold = 1'b1;
        lane_enable = '0; lane_dir_tx = '0;
        event_tick = 1'b0; wr_valid = 1'b0; wr_data = '0; dma_err_clr = 1'b0;
        @(negedge clk);
        step(1'b1, 1'b1, 32'h55, 1'b0);
        chk("R1 svc_req", {31'b0, svc_req}, 32'd0);
        chk("R1 lane_load", {28'b0, lane_load}, 32'd0);
        chk("R1 lane_word", lane_word, 32'd0);
        chk("R1 dma_err", {31'b0, dma_err}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_config(input logic [NL-1:0] en, input logic [NL-1:0] tx);
        tx_hold = 1'b1; lane_enable = en; lane_dir_tx = tx;
        step(1'b0, 1'b0, '0, 1'b0);
        tx_hold = 1'b0;
    endtask

    task automatic t_orphan;
        step(1'b0, 1'b1, 32'hDEAD, 1'b0);
        chk("R10 orphan err", {31'b0, dma_err}, 32'd1);
        chk("R10 orphan no load", {28'b0, lane_load}, 32'd0);
        step(1'b0, 1'b0, '0, 1'b1);
        chk("R7 clear", {31'b0, dma_err}, 32'd0);
    endtask

    task automatic t_full(input logic [NL-1:0] act, input int nact);
        step(1'b1, 1'b0, '0, 1'b0);
        chk("R2 req pulse", {31'b0, svc_req}, 32'd1);
        step(1'b0, 1'b0, '0, 1'b0);
        chk("R2 req single", {31'b0, svc_req}, 32'd0);
        for (int k = 0; k < nact; k++) begin
            step(1'b0, 1'b1, 32'hA000 + k, 1'b0);
            chk("R3 R4 lane", {28'b0, lane_load}, {28'b0, exp_lane(act, k)});
            chk("R3 word", lane_word, 32'hA000 + k);
        end
        chk("R5 no err yet", {31'b0, dma_err}, 32'd0);
        step(1'b0, 1'b1, 32'hBAD0, 1'b0);
        chk("R5 excess dropped", {28'b0, lane_load}, 32'd0);
        chk("R5 excess err", {31'b0, dma_err}, 32'd1);
    endtask

    task automatic t_race;
        step(1'b0, 1'b1, 32'hBAD1, 1'b1);
        chk("R7 set beats clear", {31'b0, dma_err}, 32'd1);
        step(1'b0, 1'b0, '0, 1'b1);
        chk("R7 cleared", {31'b0, dma_err}, 32'd0);
    endtask

    task automatic t_short(input logic [NL-1:0] act);
        step(1'b1, 1'b0, '0, 1'b0);
        step(1'b0, 1'b1, 32'h11, 1'b0);
        chk("R6 first lane", {28'b0, lane_load}, {28'b0, exp_lane(act, 0)});
        step(1'b1, 1'b0, '0, 1'b0);
        chk("R6 no err on short", {31'b0, dma_err}, 32'd0);
        step(1'b0, 1'b1, 32'h22, 1'b0);
        chk("R6 restart lane", {28'b0, lane_load}, {28'b0, exp_lane(act, 0)});
        step(1'b0, 1'b1, 32'h33, 1'b0);
        chk("R6 second lane", {28'b0, lane_load}, {28'b0, exp_lane(act, 1)});
    endtask

    task automatic t_tick_write(input logic [NL-1:0] act);
        step(1'b1, 1'b1, 32'h77, 1'b0);
        chk("R11 req", {31'b0, svc_req}, 32'd1);
        chk("R11 first lane", {28'b0, lane_load}, {28'b0, exp_lane(act, 0)});
        chk("R11 word", lane_word, 32'h77);
    endtask

    task automatic t_frozen(input logic [NL-1:0] act, input int nact);
        lane_enable = 4'b0001;
        step(1'b1, 1'b0, '0, 1'b0);
        for (int k = 0; k < nact; k++) begin
            step(1'b0, 1'b1, 32'hC0 + k, 1'b0);
            chk("R8 frozen lane", {28'b0, lane_load}, {28'b0, exp_lane(act, k)});
        end
        chk("R8 no err", {31'b0, dma_err}, 32'd0);
    endtask

    task automatic t_hold;
        tx_hold = 1'b1;
        step(1'b1, 1'b1, 32'h99, 1'b0);
        chk("R9 no req", {31'b0, svc_req}, 32'd0);
        chk("R9 no load", {28'b0, lane_load}, 32'd0);
        chk("R9 no err", {31'b0, dma_err}, 32'd0);
        tx_hold = 1'b0;
        step(1'b1, 1'b0, '0, 1'b0);
        step(1'b0, 1'b1, 32'h44, 1'b0);
        chk("R8 new cfg lane0", {28'b0, lane_load}, 32'd1);
        step(1'b0, 1'b1, 32'h45, 1'b0);
        chk("R8 new cfg excess", {31'b0, dma_err}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_config(4'b1111, 4'b1011);
        t_orphan();
        t_full(4'b1011, 3);
        t_race();
        t_short(4'b1011);
        t_tick_write(4'b1011);
        t_frozen(4'b1011, 3);
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule